// File: doc/BRIEF.md
# Register Transfer Execution Unit

This unit executes the register-to-register transfer group of a 32-bit processor. It holds eight general registers. It decodes one 16-bit instruction halfword per start strobe. The operations are a plain move, a one's complement, a two's complement (negate) and an exchange. Each of the four also has a variant in which the value is ANDed with general register 4, which serves as a fixed mask. A separate zero-register instruction clears one register.

Every completed instruction updates a four-bit condition code. That code reports the sign and zero state of the value written, or of the original destination in the case of an exchange. It also reports an arithmetic exception for the negate forms. An exchange swaps two registers through a single write port, so it takes two clock cycles. Undefined encodings change nothing and raise an illegal-instruction flag.

A load port places operand values into the register file. A combinational debug port reads any register back. Instruction fetch, program counter, privilege and trap dispatch are handled elsewhere, so the unit only exports the exception and illegal flags.

Top module: `regxfer_unit`

## Requirements
- R1: Instruction fields are decoded with bit 15 as the leftmost bit. instr[15:10] is the opcode: 6'h0B selects the transfer group and 6'h03 selects zero-register. instr[9:7] names the destination register, instr[6:4] names the source register and instr[3:0] is the augment code.
- R2: Augment 4'h0 copies the source register to the destination. Augment 4'h8 writes the source ANDed with register 4.
- R3: Augment 4'h3 writes the bitwise inverse of the source. Augment 4'hB writes that inverse ANDed with register 4.
- R4: Augment 4'h4 writes the two's complement of the source, so 32'h00000FFF becomes 32'hFFFFF001. Augment 4'hC writes the two's complement ANDed with register 4.
- R5: The condition code is cc[3:0] = {CC1, CC2, CC3, CC4}. CC2 means the checked value is positive as a signed number, CC3 means it is negative and CC4 means it is zero. CC1 is 0 for every form except negate.
- R6: For the two negate forms, CC1 is set and arith_exc pulses together with done exactly when the source is 32'h80000000.
- R7: Augment 4'h5 swaps the source and destination registers. The condition code comes from the original destination value. done rises two cycles after the accepting clock edge, whereas every other form completes after one cycle.
- R8: Augment 4'hD ANDs both registers with register 4 and swaps the masked values. The condition code comes from the original destination ANDed with register 4.
- R9: The zero-register instruction (opcode 6'h03, augment 4'h0, both register fields equal) clears the register and sets cc to 4'b0001.
- R10: Any other encoding, including zero-register with unequal fields, pulses illegal together with done. It leaves all registers and cc unchanged.
- R11: A start strobe that arrives while an exchange is still in progress is ignored.
- R12: After reset all registers, cc, done, illegal and arith_exc are zero. ld_en writes ld_val to register ld_idx, and dbg_val always shows register dbg_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Execute the halfword on instr |
| instr | input | 16 | Instruction halfword |
| ld_en | input | 1 | Register load strobe |
| ld_idx | input | 3 | Register to load |
| ld_val | input | 32 | Value to load |
| dbg_idx | input | 3 | Register to observe |
| dbg_val | output | 32 | Contents of register dbg_idx |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Undefined encoding, valid with done |
| arith_exc | output | 1 | Negation overflow, valid with done |
| cc | output | 4 | Condition code {CC1,CC2,CC3,CC4} |

## Verification
The hardest situation to reach is a second start that lands while an exchange is still writing its second register. A normal driver waits for done before it issues again, so this case never arises on its own. The stimulus therefore holds start high for one extra cycle during an exchange, with a conflicting move on instr. It then checks that only one completion appears and that no register shows the move. Negation overflow needs the single value 32'h80000000 in the source register, so that value is loaded on purpose before a negate is issued.

// File: rtl/regxfer_pkg.sv
package regxfer_pkg;

  localparam int NREG = 8;
  localparam int RIDX = $clog2(NREG);

  localparam logic [5:0] OPC_XFER = 6'h0B;
  localparam logic [5:0] OPC_ZERO = 6'h03;

  typedef enum logic [2:0] {
    K_MOVE,
    K_COMP,
    K_NEG,
    K_XCH,
    K_ZERO,
    K_BAD
  } xfer_kind_e;

  typedef struct packed {
    xfer_kind_e        kind;
    logic              masked;
    logic [RIDX-1:0]   rd;
    logic [RIDX-1:0]   rs;
  } xfer_op_t;

endpackage

// File: rtl/regxfer_decode.sv
module regxfer_decode
  import regxfer_pkg::*;
(
  input  logic [15:0] instr,
  output xfer_op_t    op
);

  logic [5:0] opc;
  logic [3:0] aug;

  assign opc = instr[15:10];
  assign aug = instr[3:0];

  always_comb begin
    op.rd     = instr[9:7];
    op.rs     = instr[6:4];
    op.masked = aug[3];
    op.kind   = K_BAD;
    if (opc == OPC_XFER) begin
      case (aug)
        4'h0, 4'h8: op.kind = K_MOVE;
        4'h3, 4'hB: op.kind = K_COMP;
        4'h4, 4'hC: op.kind = K_NEG;
        4'h5, 4'hD: op.kind = K_XCH;
        default:    op.kind = K_BAD;
      endcase
    end else if (opc == OPC_ZERO && aug == 4'h0 && instr[9:7] == instr[6:4]) begin
      op.kind = K_ZERO;
    end
  end

endmodule

// File: rtl/regxfer_alu.sv
module regxfer_alu
  import regxfer_pkg::*;
#(
  parameter int W = 32
) (
  input  xfer_kind_e   kind,
  input  logic         masked,
  input  logic [W-1:0] src,
  input  logic [W-1:0] dst,
  input  logic [W-1:0] msk,
  output logic [W-1:0] res,
  output logic [W-1:0] swp,
  output logic [3:0]   cc_n
);

  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] m;
  logic [W-1:0] flag;
  logic         ovf;

  assign m = masked ? msk : '1;

  always_comb begin
    res = '0;
    swp = '0;
    ovf = 1'b0;
    case (kind)
      K_MOVE: res = src & m;
      K_COMP: res = ~src & m;
      K_NEG: begin
        res = (~src + ONE) & m;
        ovf = (src == MIN_NEG);
      end
      K_XCH: begin
        res = src & m;
        swp = dst & m;
      end
      default: res = '0;
    endcase
    flag = (kind == K_XCH) ? swp : res;
    cc_n = {ovf, ~flag[W-1] & (|flag), flag[W-1], ~(|flag)};
  end

endmodule

// File: rtl/regxfer_rf.sv
module regxfer_rf #(
  parameter int W = 32,
  parameter int N = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [$clog2(N)-1:0] waddr,
  input  logic [W-1:0]         wdata,
  input  logic [$clog2(N)-1:0] ra_s,
  input  logic [$clog2(N)-1:0] ra_d,
  input  logic [$clog2(N)-1:0] ra_m,
  input  logic [$clog2(N)-1:0] ra_x,
  output logic [W-1:0]         rd_s,
  output logic [W-1:0]         rd_d,
  output logic [W-1:0]         rd_m,
  output logic [W-1:0]         rd_x
);

  localparam int AW = $clog2(N);

  logic [N-1:0][W-1:0] flat;

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic [W-1:0] q;
    logic         en;
    assign en = we && (waddr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wdata;
    end
    assign flat[g] = q;
  end

  assign rd_s = flat[ra_s];
  assign rd_d = flat[ra_d];
  assign rd_m = flat[ra_m];
  assign rd_x = flat[ra_x];

endmodule

// File: rtl/regxfer_unit.sv
module regxfer_unit
  import regxfer_pkg::*;
#(
  parameter int W        = 32,
  parameter int MASK_IDX = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [15:0]      instr,
  input  logic             ld_en,
  input  logic [2:0]       ld_idx,
  input  logic [W-1:0]     ld_val,
  input  logic [2:0]       dbg_idx,
  output logic [W-1:0]     dbg_val,
  output logic             done,
  output logic             illegal,
  output logic             arith_exc,
  output logic [3:0]       cc
);

  localparam logic [RIDX-1:0] MIDX = RIDX'(MASK_IDX);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  xfer_op_t     op;
  xfer_kind_e   kind_w;
  logic [W-1:0] src_v, dst_v, msk_v, res_v, swp_v;
  logic [3:0]   cc_n;

  regxfer_decode u_dec (.instr(instr), .op(op));
  assign kind_w = op.kind;

  // state
  logic            busy_q, busy_d;
  logic [W-1:0]    pend_q;
  logic [RIDX-1:0] pidx_q;
  logic            pend_en;
  logic            done_q, done_d;
  logic            ill_q, ill_d;
  logic            exc_q, exc_d;
  logic [3:0]      cc_q;
  logic            cc_en;
  logic            accept;

  // single write port
  logic            we;
  logic [RIDX-1:0] wa;
  logic [W-1:0]    wd;

  regxfer_rf #(.W(W), .N(NREG)) u_rf (
    .clk(clk), .rst_n(rst_i_n),
    .we(we), .waddr(wa), .wdata(wd),
    .ra_s(op.rs), .ra_d(op.rd), .ra_m(MIDX), .ra_x(dbg_idx),
    .rd_s(src_v), .rd_d(dst_v), .rd_m(msk_v), .rd_x(dbg_val)
  );

  regxfer_alu #(.W(W)) u_alu (
    .kind(op.kind), .masked(op.masked),
    .src(src_v), .dst(dst_v), .msk(msk_v),
    .res(res_v), .swp(swp_v), .cc_n(cc_n)
  );

  always_comb begin
    accept  = start && !busy_q;
    busy_d  = accept && (op.kind == K_XCH);
    pend_en = busy_d;
    done_d  = (accept && (op.kind != K_XCH)) || busy_q;
    ill_d   = accept && (op.kind == K_BAD);
    exc_d   = accept && cc_n[3];
    cc_en   = accept && (op.kind != K_BAD);
    we = 1'b0;
    wa = ld_idx;
    wd = ld_val;
    if (busy_q) begin
      we = 1'b1;
      wa = pidx_q;
      wd = pend_q;
    end else if (accept && op.kind != K_BAD) begin
      we = 1'b1;
      wa = op.rd;
      wd = res_v;
    end else if (ld_en) begin
      we = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      exc_q  <= 1'b0;
      cc_q   <= '0;
      pend_q <= '0;
      pidx_q <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      ill_q  <= ill_d;
      exc_q  <= exc_d;
      if (cc_en)   cc_q <= cc_n;
      if (pend_en) begin
        pend_q <= swp_v;
        pidx_q <= op.rs;
      end
    end
  end

  assign done      = done_q;
  assign illegal   = ill_q;
  assign arith_exc = exc_q;
  assign cc        = cc_q;

endmodule

// File: rtl/regxfer_checker.sv
module regxfer_checker
  import regxfer_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input xfer_kind_e kind,
  input logic       done,
  input logic       illegal,
  input logic       arith_exc,
  input logic [3:0] cc
);

  assert_illegal_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done);

  assert_illegal_keeps_cc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && illegal) |-> cc == $past(cc));

  assert_exc_sets_cc1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    arith_exc |-> (done && cc[3]));

  assert_cc_one_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !illegal) |-> $countones(cc[2:0]) == 1);

  assert_xch_second_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && kind == K_XCH) |=> (busy && !done));

  assert_busy_then_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (done && !busy));

  assert_zero_cc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && kind == K_ZERO) |=> (done && !illegal && cc == 4'b0001));

endmodule

bind regxfer_unit regxfer_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy_q), .kind(kind_w),
  .done(done), .illegal(illegal), .arith_exc(arith_exc), .cc(cc)
);

// File: tb/regxfer_unit_bench.sv
module regxfer_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr = '0;
  logic        ld_en = 1'b0;
  logic [2:0]  ld_idx = '0;
  logic [31:0] ld_val = '0;
  logic [2:0]  dbg_idx = '0;
  logic [31:0] dbg_val;
  logic        done, illegal, arith_exc;
  logic [3:0]  cc;

  always #10 clk = ~clk;

  regxfer_unit u_regxfer_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_val(ld_val),
    .dbg_idx(dbg_idx), .dbg_val(dbg_val),
    .done(done), .illegal(illegal), .arith_exc(arith_exc), .cc(cc)
  );

  typedef struct {
    logic [3:0] cc;
    logic       ill;
    logic       exc;
    int         lat;
    string      req;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] mdl[8];
  logic [3:0]  cur_cc = '0;
  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;
  int          issue_cyc = 0;
  bit          finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  function automatic logic [3:0] flags(input logic e, input logic [31:0] v);
    return {e, $signed(v) > 0, $signed(v) < 0, v == 32'd0};
  endfunction

  // monitor: compare each completion against the scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        chk(0, "R11", "unexpected done", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(illegal == e.ill, e.req, "illegal", 32'(illegal), 32'(e.ill));
        chk(cc == e.cc, e.req, "cc", 32'(cc), 32'(e.cc));
        chk(arith_exc == e.exc, e.req, "arith_exc", 32'(arith_exc), 32'(e.exc));
        chk((cyc - issue_cyc) == e.lat, e.req, "latency", 32'(cyc - issue_cyc), 32'(e.lat));
      end
    end
  end

  // expected result of one instruction, applied to the model
  function automatic exp_t predict(input logic [15:0] ins, input string req);
    exp_t        e;
    logic [2:0]  d, s;
    logic [3:0]  a;
    logic [31:0] mk, v, t;
    d = ins[9:7];
    s = ins[6:4];
    a = ins[3:0];
    mk = a[3] ? mdl[4] : 32'hFFFF_FFFF;
    e.ill = 1'b0; e.exc = 1'b0; e.lat = 1; e.req = req;
    e.cc = cur_cc;
    if (ins[15:10] == 6'h0B && (a == 4'h0 || a == 4'h8)) begin
      v = mdl[s] & mk; mdl[d] = v; e.cc = flags(0, v);
    end else if (ins[15:10] == 6'h0B && (a == 4'h3 || a == 4'hB)) begin
      v = ~mdl[s] & mk; mdl[d] = v; e.cc = flags(0, v);
    end else if (ins[15:10] == 6'h0B && (a == 4'h4 || a == 4'hC)) begin
      e.exc = (mdl[s] == 32'h8000_0000);
      v = (32'd0 - mdl[s]) & mk; mdl[d] = v; e.cc = flags(e.exc, v);
    end else if (ins[15:10] == 6'h0B && (a == 4'h5 || a == 4'hD)) begin
      v = mdl[s] & mk; t = mdl[d] & mk;
      mdl[d] = v; mdl[s] = t; e.cc = flags(0, t); e.lat = 2;
    end else if (ins[15:10] == 6'h03 && a == 4'h0 && d == s) begin
      mdl[d] = 32'd0; e.cc = 4'b0001;
    end else begin
      e.ill = 1'b1;
    end
    if (!e.ill) cur_cc = e.cc;
    return e;
  endfunction

  task automatic check_regs(input string req);
    for (int i = 0; i < 8; i++) begin
      dbg_idx = 3'(i);
      #1;
      chk(dbg_val == mdl[i], req, $sformatf("reg %0d", i), dbg_val, mdl[i]);
    end
  endtask

  task automatic issue(input logic [15:0] ins, input string req, input bit hold_extra,
                       input logic [15:0] extra);
    sb.push_back(predict(ins, req));
    @(negedge clk);
    instr = ins; start = 1'b1; issue_cyc = cyc;
    @(negedge clk);
    if (hold_extra) begin
      instr = extra;
      @(negedge clk);
    end
    start = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
    check_regs(req);
  endtask

  task automatic load(input int i, input logic [31:0] v);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = 3'(i); ld_val = v;
    mdl[i] = v;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  function automatic logic [15:0] xf(input logic [2:0] d, input logic [2:0] s, input logic [3:0] a);
    return {6'h0B, d, s, a};
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R7 watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk(done == 0 && illegal == 0 && arith_exc == 0, "R12", "reset flags",
        {29'd0, done, illegal, arith_exc}, 32'd0);
    chk(cc == 4'd0, "R12", "reset cc", 32'(cc), 32'd0);
    check_regs("R12");

    load(2, 32'h000803AB); load(4, 32'h0007FFF0); load(6, 32'h00000FFF);
    load(7, 32'h12345678); load(3, 32'h80000000); load(5, 32'h55555555);
    check_regs("R12");

    issue(xf(1, 2, 4'h0), "R1", 0, 0);      // plain move, R2
    issue(xf(0, 7, 4'h8), "R2", 0, 0);      // masked move
    issue(xf(7, 5, 4'h3), "R3", 0, 0);      // inverse, negative
    issue(xf(1, 5, 4'hB), "R3", 0, 0);      // masked inverse
    issue(xf(7, 6, 4'h4), "R4", 0, 0);      // FFFFF001, CC3
    load(4, 32'h7FFFFFFF);
    issue(xf(7, 6, 4'hC), "R4", 0, 0);      // masked negate, CC2
    issue(xf(0, 3, 4'h4), "R6", 0, 0);      // overflow
    issue(xf(2, 3, 4'hC), "R6", 0, 0);      // masked overflow
    load(0, 32'd0);
    issue(xf(6, 0, 4'h4), "R5", 0, 0);      // negate zero, CC4
    issue(xf(1, 2, 4'h5), "R7", 0, 0);      // exchange
    issue(xf(3, 3, 4'h5), "R7", 0, 0);      // exchange with itself
    load(4, 32'h000FFFFF);
    issue(xf(2, 7, 4'hD), "R8", 0, 0);      // masked exchange
    issue({6'h03, 3'd1, 3'd1, 4'h0}, "R9", 0, 0);
    issue({6'h03, 3'd5, 3'd6, 4'h0}, "R10", 0, 0);
    issue(xf(5, 6, 4'h1), "R10", 0, 0);
    issue({6'h3F, 3'd5, 3'd6, 4'h0}, "R10", 0, 0);
    // start held during exchange second cycle: conflicting move must be ignored
    issue(xf(5, 6, 4'h5), "R11", 1, xf(0, 5, 4'h0));
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R11", "scoreboard empty", 32'(sb.size()), 32'd0);

    finished = 1;
    summary();
    $finish;
  end

endmodule